// File: doc/BRIEF.md
# Floppy Disk Controller Host Command Sequencer

This block is the byte-wide face of a floppy disk controller as seen by a host processor. The host polls an 8-bit main status word. Through one data port it writes command bytes, moves execution-phase data in either direction, and reads back result bytes one at a time. The sequencer uses the opcode in the first byte to decide how many bytes the command has. After the last byte it spends one dispatch cycle, then enters an execution phase, a result phase, or idle.

Drive access is reduced to stubs so that only sequencing and status encoding are exercised. A single `drv_ready` level stands for the selected drive. Execution-phase data from the drive is a counting pattern that starts at the sector number. Host-written execution data is accepted and discarded. A level interrupt goes high a fixed number of cycles after a data command reaches its results, or after a seek or recalibrate. SENSE INTERRUPT STATUS collects the seek result and acknowledges it.

Top module: `fdc_seq`

## Requirements
- R1: The opcode is bits 4:0 of the first command byte; bits 7:5 do not change the length. The total length is 9 bytes for codes 2, 5, 6, 9, 12, 17, 25 and 30; 6 bytes for code 13; 3 bytes for codes 3 and 15; 2 bytes for codes 4, 7 and 10; and 1 byte for every other code, including 8.
- R2: While more command bytes are expected, `msr` reads 0x90. During the single dispatch cycle after the last command byte, `msr` reads 0x10.
- R3: Read-type commands (codes 2, 6, 12) with the drive ready make `msr` read 0xF0 for EXEC_LEN host reads. Byte k of that data equals (R + k) mod 256, where R is command byte 4. Write-type commands (codes 5, 9, 13, 17, 25, 30) make `msr` read 0xB0 for EXEC_LEN host writes.
- R4: Data commands and READ ID return 7 result bytes while `msr` reads 0xD0. The bytes are, in order, ST0, ST1, ST2, then command bytes 2, 3, 4 and 5. Bits 2:0 of ST0 equal bits 2:0 of command byte 1. ST1 is 0. ST2 is 0x08 for a scan with the drive ready, otherwise 0.
- R5: If `drv_ready` is low at dispatch, a data command skips its execution phase and goes straight to the 7 results. The same applies to READ ID. In both cases ST0 = 0x48 OR the drive/head bits.
- R6: An opcode not listed in R1 as a real command gives one result byte: the previous ST0 with bits 7:6 forced to 10. That value also becomes the new ST0.
- R7: SENSE DRIVE STATUS (code 4) returns one byte. Bit 5 of that byte is `drv_ready`, bits 2:0 are the drive/head bits, and all other bits are 0.
- R8: SPECIFY (code 3) returns to idle (0x80) after dispatch with no result phase.
- R9: SEEK (code 15) and RECALIBRATE (code 7) return to idle after dispatch. They set ST0 = 0x20 OR the drive/head bits, plus 0x48 if the drive is not ready. If the drive is ready, the cylinder becomes command byte 2 (SEEK) or 0 (RECALIBRATE). `irq` rises IRQ_DELAY cycles after dispatch.
- R10: SENSE INTERRUPT STATUS (code 8) returns ST0 and the cylinder if a seek-end interrupt is pending. Otherwise it returns the single byte 0x80 and sets ST0 to 0x80. In both cases it drops `irq` and clears the pending interrupt.
- R11: A high `tc` during an execution phase moves the block to the 7-byte result phase on the next clock.
- R12: `irq` rises IRQ_DELAY cycles after a data command or READ ID enters its result phase. Any data-port read or write clears that interrupt. A pending seek-end interrupt survives data-port accesses.
- R13: Reading the last result byte returns the block to idle, with `msr` at 0x80.
- R14: After reset, `msr` is 0x80, `irq` is 0 and `rd_data` is 0x00. `rd_data` is also 0x00 whenever the block is neither in a result phase nor sending execution data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | One-cycle data port read strobe |
| wr_stb | input | 1 | One-cycle data port write strobe |
| wr_data | input | 8 | Byte written to the data port |
| tc | input | 1 | Terminal count, ends an execution phase |
| drv_ready | input | 1 | Ready level from the selected drive stub |
| msr | output | 8 | Registered main status word |
| rd_data | output | 8 | Byte presented on the data port |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is a seek-end interrupt that must outlive unrelated traffic on the data port. The stimulus issues a SEEK and then a full SPECIFY, so data writes land both before and after `irq` rises. SENSE INTERRUPT STATUS must still report the new cylinder afterwards. A second hard case is a terminal count raised partway through an execution transfer; the bench stops a read after two of its bytes. The opposite order is also covered: a data command's result interrupt replaces a pending seek interrupt, so a later SENSE INTERRUPT STATUS must give 0x80.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

  localparam int RES_MAX = 7;
  localparam int RPW     = $clog2(RES_MAX + 1);

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_DISP, PH_XOUT, PH_XIN, PH_RES
  } phase_t;

  typedef enum logic [1:0] {IK_NONE, IK_RES, IK_SEEK} ikind_t;

  typedef enum logic [3:0] {
    CL_BAD, CL_RDX, CL_WRX, CL_SCAN, CL_RDID, CL_SDRV,
    CL_SPEC, CL_SEEK, CL_RECAL, CL_SINT
  } cls_t;

  function automatic logic [7:0] msr_code(phase_t p);
    case (p)
      PH_CMD:  return 8'h90;
      PH_DISP: return 8'h10;
      PH_XOUT: return 8'hF0;
      PH_XIN:  return 8'hB0;
      PH_RES:  return 8'hD0;
      default: return 8'h80;
    endcase
  endfunction

endpackage

// File: rtl/fdc_opc_decode.sv
module fdc_opc_decode
  import fdc_seq_pkg::*;
(
  input  logic [4:0] op,
  output logic [3:0] len,
  output cls_t       cls
);
  always_comb begin
    len = 4'd1;
    cls = CL_BAD;
    case (op)
      5'd2, 5'd6, 5'd12:   begin len = 4'd9; cls = CL_RDX;  end
      5'd5, 5'd9:          begin len = 4'd9; cls = CL_WRX;  end
      5'd17, 5'd25, 5'd30: begin len = 4'd9; cls = CL_SCAN; end
      5'd13:               begin len = 4'd6; cls = CL_WRX;  end
      5'd3:                begin len = 4'd3; cls = CL_SPEC; end
      5'd15:               begin len = 4'd3; cls = CL_SEEK; end
      5'd4:                begin len = 4'd2; cls = CL_SDRV; end
      5'd7:                begin len = 4'd2; cls = CL_RECAL; end
      5'd10:               begin len = 4'd2; cls = CL_RDID; end
      5'd8:                begin len = 4'd1; cls = CL_SINT; end
      default:             begin len = 4'd1; cls = CL_BAD;  end
    endcase
  end
endmodule

// File: rtl/fdc_irq_timer.sv
module fdc_irq_timer
  import fdc_seq_pkg::*;
#(
  parameter int IRQ_DELAY = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic start_seek,
  input  logic soft_clr,
  input  logic clr_all,
  output logic irq,
  output logic seek_pend
);
  localparam int CW = $clog2(IRQ_DELAY + 1);

  logic [CW-1:0] cnt;
  ikind_t        kind;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0; irq <= 1'b0; kind <= IK_NONE;
    end else if (clr_all) begin
      cnt <= '0; irq <= 1'b0; kind <= IK_NONE;
    end else if (start) begin
      cnt  <= CW'(IRQ_DELAY);
      irq  <= 1'b0;
      kind <= start_seek ? IK_SEEK : IK_RES;
    end else if (soft_clr && kind != IK_SEEK) begin
      cnt <= '0; irq <= 1'b0; kind <= IK_NONE;
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) irq <= 1'b1;
    end
  end

  assign seek_pend = (kind == IK_SEEK);

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(cnt) == CW'(1)));
  // R12
  seek_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == IK_SEEK && soft_clr && !clr_all && !start) |=> (kind == IK_SEEK));
  // R10
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (!irq && kind == IK_NONE));
endmodule

// File: rtl/fdc_result_buf.sv
module fdc_result_buf
  import fdc_seq_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [RPW-1:0]           len,
  input  logic [RES_MAX-1:0][7:0]  data,
  input  logic                     pop,
  output logic [7:0]               byte_o,
  output logic                     last
);
  logic [7:0]     mem [RES_MAX];
  logic [RPW-1:0] len_q, rptr;

  always_ff @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < RES_MAX; i++) mem[i] <= data[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0; rptr <= '0;
    end else if (load) begin
      len_q <= len; rptr <= '0;
    end else if (pop && len_q != '0) begin
      if (last) begin
        len_q <= '0; rptr <= '0;
      end else begin
        rptr <= rptr + RPW'(1);
      end
    end
  end

  assign last   = (len_q != '0) && (rptr == len_q - RPW'(1));
  assign byte_o = mem[rptr];

  // R4
  rptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    (len_q != '0) |-> (rptr < len_q));
endmodule

// File: rtl/fdc_seq.sv
module fdc_seq
  import fdc_seq_pkg::*;
#(
  parameter int EXEC_LEN  = 4,
  parameter int IRQ_DELAY = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_stb,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  input  logic       tc,
  input  logic       drv_ready,
  output logic [7:0] msr,
  output logic [7:0] rd_data,
  output logic       irq
);
  localparam int XW   = $clog2(EXEC_LEN + 1);
  localparam int CHRN = 4;

  phase_t          phase, phase_n;
  logic [4:0]      op_q, op_sel;
  logic [2:0]      ds_q;
  logic [7:0]      chrn [CHRN];
  logic [3:0]      cpos, need, len_dec;
  logic [1:0]      cidx;
  cls_t            cls;
  logic [7:0]      st0, st1, st2, cyl, st0_n, st1_n, st2_n, cyl_n;
  logic [XW-1:0]   xcnt, xcnt_n, xidx;
  logic            rb_load, rb_full, rb_last, nr;
  logic [RPW-1:0]  rb_len;
  logic [RES_MAX-1:0][7:0] rb_data;
  logic [7:0]      rb_byte;
  logic            irq_start, irq_seek, irq_clr, seek_pend;

  assign op_sel = (phase == PH_IDLE) ? wr_data[4:0] : op_q;
  assign nr     = !drv_ready;
  assign cidx   = 2'(cpos - 4'd2);
  assign xidx   = XW'(EXEC_LEN) - xcnt;

  fdc_opc_decode u_dec (.op(op_sel), .len(len_dec), .cls(cls));

  // command byte capture
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q <= '0; ds_q <= '0; cpos <= '0; need <= '0;
      for (int i = 0; i < CHRN; i++) chrn[i] <= '0;
    end else if (wr_stb && phase == PH_IDLE) begin
      op_q <= wr_data[4:0];
      cpos <= 4'd1;
      need <= len_dec - 4'd1;
    end else if (wr_stb && phase == PH_CMD) begin
      cpos <= cpos + 4'd1;
      need <= need - 4'd1;
      if (cpos == 4'd1) ds_q <= wr_data[2:0];
      if (cpos >= 4'd2 && cpos <= 4'd5) chrn[cidx] <= wr_data;
    end
  end

  // next-state: phases, status bytes, result loading
  always_comb begin
    phase_n = phase; st0_n = st0; st1_n = st1; st2_n = st2; cyl_n = cyl;
    xcnt_n = xcnt; rb_load = 1'b0; rb_full = 1'b0; rb_len = RPW'(RES_MAX);
    rb_data = '0; irq_start = 1'b0; irq_seek = 1'b0; irq_clr = 1'b0;
    case (phase)
      PH_IDLE: if (wr_stb) phase_n = (len_dec == 4'd1) ? PH_DISP : PH_CMD;
      PH_CMD:  if (wr_stb && need == 4'd1) phase_n = PH_DISP;
      PH_DISP: begin
        case (cls)
          CL_RDX, CL_WRX, CL_SCAN, CL_RDID: begin
            st0_n = (nr ? 8'h48 : 8'h00) | {5'd0, ds_q};
            st1_n = 8'h00;
            st2_n = (cls == CL_SCAN && !nr) ? 8'h08 : 8'h00;
            if (nr || cls == CL_RDID) begin
              phase_n = PH_RES; rb_load = 1'b1; rb_full = 1'b1; irq_start = 1'b1;
            end else begin
              phase_n = (cls == CL_RDX) ? PH_XOUT : PH_XIN;
              xcnt_n  = XW'(EXEC_LEN);
            end
          end
          CL_SDRV: begin
            st0_n = {st0[7:3], ds_q};
            phase_n = PH_RES; rb_load = 1'b1; rb_len = RPW'(1);
            rb_data[0] = {2'b00, drv_ready, 2'b00, ds_q};
          end
          CL_SPEC: phase_n = PH_IDLE;
          CL_SEEK, CL_RECAL: begin
            st0_n = 8'h20 | (nr ? 8'h48 : 8'h00) | {5'd0, ds_q};
            st1_n = 8'h00;
            if (!nr) cyl_n = (cls == CL_SEEK) ? chrn[0] : 8'h00;
            phase_n = PH_IDLE; irq_start = 1'b1; irq_seek = 1'b1;
          end
          CL_SINT: begin
            phase_n = PH_RES; rb_load = 1'b1; irq_clr = 1'b1;
            if (seek_pend) begin
              rb_len = RPW'(2); rb_data[0] = st0; rb_data[1] = cyl;
            end else begin
              st0_n = 8'h80; rb_len = RPW'(1); rb_data[0] = 8'h80;
            end
          end
          default: begin
            st0_n = {2'b10, st0[5:0]};
            phase_n = PH_RES; rb_load = 1'b1; rb_len = RPW'(1);
            rb_data[0] = {2'b10, st0[5:0]};
          end
        endcase
      end
      PH_XOUT, PH_XIN: begin
        if (tc) begin
          phase_n = PH_RES; rb_load = 1'b1; rb_full = 1'b1; irq_start = 1'b1;
        end else if ((phase == PH_XOUT) ? rd_stb : wr_stb) begin
          xcnt_n = xcnt - XW'(1);
          if (xcnt == XW'(1)) begin
            phase_n = PH_RES; rb_load = 1'b1; rb_full = 1'b1; irq_start = 1'b1;
          end
        end
      end
      PH_RES:  if (rd_stb && rb_last) phase_n = PH_IDLE;
      default: phase_n = PH_IDLE;
    endcase
    if (rb_full) rb_data = {chrn[3], chrn[2], chrn[1], chrn[0], st2_n, st1_n, st0_n};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE; msr <= 8'h80; xcnt <= '0;
      st0 <= '0; st1 <= '0; st2 <= '0; cyl <= '0;
    end else begin
      phase <= phase_n; msr <= msr_code(phase_n); xcnt <= xcnt_n;
      st0 <= st0_n; st1 <= st1_n; st2 <= st2_n; cyl <= cyl_n;
    end
  end

  fdc_result_buf u_res (
    .clk(clk), .rst(rst), .load(rb_load), .len(rb_len), .data(rb_data),
    .pop(rd_stb && phase == PH_RES), .byte_o(rb_byte), .last(rb_last)
  );

  fdc_irq_timer #(.IRQ_DELAY(IRQ_DELAY)) u_irq (
    .clk(clk), .rst(rst), .start(irq_start), .start_seek(irq_seek),
    .soft_clr(rd_stb || wr_stb), .clr_all(irq_clr), .irq(irq), .seek_pend(seek_pend)
  );

  assign rd_data = (phase == PH_RES)  ? rb_byte :
                   (phase == PH_XOUT) ? chrn[2] + 8'(xidx) : 8'h00;

  // R13
  res_done_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RES && rd_stb && rb_last) |=> (msr == 8'h80));
  // R11
  tc_stop_chk: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_XOUT || phase == PH_XIN) && tc) |=> (msr == 8'hD0));
  // R3
  xfer_live_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_XOUT || phase == PH_XIN) |-> (xcnt != '0));
  // R2
  busy_set_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && wr_stb) |=> msr[4]);
endmodule

// File: tb/test_fdc_seq.sv
module test_fdc_seq;
  localparam int EXEC_LEN  = 4;
  localparam int IRQ_DELAY = 6;

  logic clk = 1'b0;
  logic rst = 1'b1, rd_stb = 1'b0, wr_stb = 1'b0, tc = 1'b0, drv_ready = 1'b1;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] msr, rd_data;
  logic irq;

  always #10 clk = ~clk;

  fdc_seq #(.EXEC_LEN(EXEC_LEN), .IRQ_DELAY(IRQ_DELAY)) i_fdc_seq (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
    .tc(tc), .drv_ready(drv_ready), .msr(msr), .rd_data(rd_data), .irq(irq)
  );

  int vectors = 0, miscompares = 0;
  string cur_req = "R14";
  bit started = 0;

  // ---------------- behavioural reference model ----------------
  int mph = 0;                 // 0 idle 1 cmd 2 disp 3 out 4 in 5 result
  logic [7:0] mc [9];
  int mpos = 0, mneed = 0, mxk = 0;
  logic [7:0] mres [$];
  logic [7:0] m_st0 = 0, m_st1 = 0, m_st2 = 0, m_cyl = 0;
  int micnt = 0, mkind = 0;    // kind: 0 none 1 result 2 seek
  bit mirq = 0;

  function automatic int cmd_len(logic [4:0] o);
    case (o)
      2, 5, 6, 9, 12, 17, 25, 30: return 9;
      13: return 6;
      3, 15: return 3;
      4, 7, 10: return 2;
      default: return 1;
    endcase
  endfunction

  task automatic m_load7();
    mres = {m_st0, m_st1, m_st2, mc[2], mc[3], mc[4], mc[5]};
  endtask

  always @(posedge clk) begin
    bit st, sk, ca, nr;
    logic [4:0] o;
    logic [2:0] d;
    started = 1;
    if (rst) begin
      mph = 0; mpos = 0; mneed = 0; mxk = 0; mres = {};
      foreach (mc[i]) mc[i] = 8'h00;
      m_st0 = 0; m_st1 = 0; m_st2 = 0; m_cyl = 0; micnt = 0; mkind = 0; mirq = 0;
    end else begin
      st = 0; sk = 0; ca = 0;
      case (mph)
        0: if (wr_stb) begin
             mc[0] = wr_data; mpos = 1; mneed = cmd_len(wr_data[4:0]) - 1;
             mph = (mneed == 0) ? 2 : 1;
           end
        1: if (wr_stb) begin
             mc[mpos] = wr_data; mpos++; mneed--;
             if (mneed == 0) mph = 2;
           end
        2: begin
          o = mc[0][4:0]; d = mc[1][2:0]; nr = !drv_ready;
          case (o)
            2, 6, 12, 5, 9, 13, 17, 25, 30, 10: begin
              m_st0 = (nr ? 8'h48 : 8'h00) | {5'd0, d}; m_st1 = 0;
              m_st2 = ((o == 17 || o == 25 || o == 30) && !nr) ? 8'h08 : 8'h00;
              if (nr || o == 10) begin m_load7(); mph = 5; st = 1; end
              else begin mxk = 0; mph = (o == 2 || o == 6 || o == 12) ? 3 : 4; end
            end
            4: begin m_st0 = {m_st0[7:3], d}; mres = {{2'b00, !nr, 2'b00, d}}; mph = 5; end
            3: mph = 0;
            15, 7: begin
              m_st0 = 8'h20 | (nr ? 8'h48 : 8'h00) | {5'd0, d}; m_st1 = 0;
              if (!nr) m_cyl = (o == 15) ? mc[2] : 8'h00;
              mph = 0; st = 1; sk = 1;
            end
            8: begin
              if (mkind == 2) mres = {m_st0, m_cyl};
              else begin m_st0 = 8'h80; mres = {8'h80}; end
              mph = 5; ca = 1;
            end
            default: begin m_st0 = {2'b10, m_st0[5:0]}; mres = {m_st0}; mph = 5; end
          endcase
        end
        3, 4: if (tc) begin m_load7(); mph = 5; st = 1; end
              else if ((mph == 3) ? rd_stb : wr_stb) begin
                mxk++;
                if (mxk == EXEC_LEN) begin m_load7(); mph = 5; st = 1; end
              end
        5: if (rd_stb) begin
             void'(mres.pop_front());
             if (mres.size() == 0) mph = 0;
           end
        default: mph = 0;
      endcase
      if (ca) begin micnt = 0; mirq = 0; mkind = 0; end
      else if (st) begin micnt = IRQ_DELAY; mirq = 0; mkind = sk ? 2 : 1; end
      else if ((rd_stb || wr_stb) && mkind != 2) begin micnt = 0; mirq = 0; mkind = 0; end
      else if (micnt != 0) begin micnt--; if (micnt == 0) mirq = 1; end
    end
  end

  function automatic logic [7:0] exp_msr();
    case (mph)
      1: return 8'h90; 2: return 8'h10; 3: return 8'hF0;
      4: return 8'hB0; 5: return 8'hD0; default: return 8'h80;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd();
    if (mph == 5 && mres.size() > 0) return mres[0];
    if (mph == 3) return mc[4] + 8'(mxk);
    return 8'h00;
  endfunction

  always @(negedge clk) if (started) begin
    vectors++;
    if (msr !== exp_msr() || rd_data !== exp_rd() || irq !== mirq) begin
      miscompares++;
      $display("FAIL %s: msr=%h exp %h, rd_data=%h exp %h, irq=%b exp %b",
               cur_req, msr, exp_msr(), rd_data, exp_rd(), irq, mirq);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_put(logic [7:0] b);
    @(negedge clk); wr_data = b; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic rd_get(output logic [7:0] v);
    @(negedge clk); v = rd_data; rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd9(logic [7:0] op, logic [7:0] u, logic [7:0] c,
                      logic [7:0] h, logic [7:0] r, logic [7:0] n);
    wr_put(op); wr_put(u); wr_put(c); wr_put(h); wr_put(r); wr_put(n);
    wr_put(8'h09); wr_put(8'h1B); wr_put(8'hFF);
  endtask

  task automatic read_res(int cnt);
    logic [7:0] v;
    for (int i = 0; i < cnt; i++) rd_get(v);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  // ---------------- test sequence ----------------
  initial begin
    logic [7:0] v;
    cur_req = "R14";
    idle(3); @(negedge clk); rst = 1'b0;
    idle(2);
    chk("R14", msr, 8'h80); chk("R14", rd_data, 8'h00);

    // R8 / R1 / R2: SPECIFY, three bytes
    cur_req = "R8";
    wr_put(8'h03);
    chk("R2", msr, 8'h90);
    wr_put(8'hAF); wr_put(8'h02);
    idle(2); chk("R8", msr, 8'h80);

    // R10: sense interrupt with nothing pending
    cur_req = "R10";
    wr_put(8'h08); idle(1);
    rd_get(v); chk("R10", v, 8'h80);
    idle(1); chk("R13", msr, 8'h80);

    // R6: unknown opcodes
    cur_req = "R6";
    wr_put(8'h01); idle(1); rd_get(v); chk("R6", v, 8'h80);
    wr_put(8'hFF); idle(1); read_res(1);
    wr_put(8'h0B); idle(1); read_res(1);

    // R3 / R4 / R12 / R13: READ with upper flag bits, unit 1
    cur_req = "R3";
    cmd9(8'hE6, 8'h01, 8'h10, 8'h00, 8'h03, 8'h02);
    idle(1); chk("R3", msr, 8'hF0);
    rd_get(v); chk("R3", v, 8'h03);
    rd_get(v); chk("R3", v, 8'h04);
    rd_get(v); chk("R3", v, 8'h05);
    rd_get(v); chk("R3", v, 8'h06);
    cur_req = "R12";
    idle(IRQ_DELAY + 1); chk("R12", {7'd0, irq}, 8'h01);
    cur_req = "R4";
    rd_get(v); chk("R4", v, 8'h01);
    chk("R12", {7'd0, irq}, 8'h00);
    rd_get(v); chk("R4", v, 8'h00);
    rd_get(v); chk("R4", v, 8'h00);
    rd_get(v); chk("R4", v, 8'h10);
    rd_get(v); chk("R4", v, 8'h00);
    rd_get(v); chk("R4", v, 8'h03);
    rd_get(v); chk("R4", v, 8'h02);
    cur_req = "R13";
    idle(1); chk("R13", msr, 8'h80);

    // R3: WRITE DELETED, host supplies data
    cur_req = "R3";
    cmd9(8'h49, 8'h06, 8'h21, 8'h01, 8'h07, 8'h01);
    idle(1); chk("R3", msr, 8'hB0);
    for (int i = 0; i < EXEC_LEN; i++) wr_put(8'(8'h55 + i));
    idle(IRQ_DELAY + 2); read_res(7);

    // R11: terminal count in the middle of a read
    cur_req = "R11";
    cmd9(8'h06, 8'h00, 8'h05, 8'h00, 8'hFE, 8'h02);
    rd_get(v); chk("R3", v, 8'hFE);
    rd_get(v); chk("R3", v, 8'hFF);
    @(negedge clk); tc = 1'b1; @(negedge clk); tc = 1'b0;
    chk("R11", msr, 8'hD0);
    read_res(7);

    // R11 on a write-direction phase (format)
    wr_put(8'h0D); wr_put(8'h02); wr_put(8'h02); wr_put(8'h09);
    wr_put(8'h2A); wr_put(8'hE5);
    wr_put(8'hAA);
    @(negedge clk); tc = 1'b1; @(negedge clk); tc = 1'b0;
    read_res(7);

    // R4: scan equal sets ST2 = 0x08
    cur_req = "R4";
    cmd9(8'h11, 8'h02, 8'h03, 8'h00, 8'h01, 8'h02);
    for (int i = 0; i < EXEC_LEN; i++) wr_put(8'h00);
    idle(1);
    rd_get(v); chk("R4", v, 8'h02);
    rd_get(v); rd_get(v); chk("R4", v, 8'h08);
    read_res(4);

    // R5: drive not ready
    cur_req = "R5";
    drv_ready = 1'b0;
    cmd9(8'h02, 8'h05, 8'h01, 8'h01, 8'h01, 8'h02);
    idle(1); chk("R5", msr, 8'hD0);
    rd_get(v); chk("R5", v, 8'h4D);
    read_res(6);
    wr_put(8'h0A); wr_put(8'h03); idle(1);
    rd_get(v); chk("R5", v, 8'h4B);
    read_res(6);

    // R7: sense drive status, not ready then ready
    cur_req = "R7";
    wr_put(8'h04); wr_put(8'h07); idle(1);
    rd_get(v); chk("R7", v, 8'h07);
    drv_ready = 1'b1;
    wr_put(8'h04); wr_put(8'h05); idle(1);
    rd_get(v); chk("R7", v, 8'h25);

    // READ ID with drive ready
    cur_req = "R4";
    wr_put(8'h4A); wr_put(8'h01); idle(1);
    rd_get(v); chk("R4", v, 8'h01);
    read_res(6);

    // R9 / R12: seek survives data-port traffic
    cur_req = "R9";
    wr_put(8'h0F); wr_put(8'h06); wr_put(8'h22);
    idle(1); chk("R9", msr, 8'h80);
    cur_req = "R12";
    wr_put(8'h03); wr_put(8'h11);
    idle(IRQ_DELAY);
    chk("R9", {7'd0, irq}, 8'h01);
    wr_put(8'h22);
    chk("R12", {7'd0, irq}, 8'h01);
    cur_req = "R10";
    wr_put(8'h08); idle(1);
    chk("R10", {7'd0, irq}, 8'h00);
    rd_get(v); chk("R10", v, 8'h26);
    rd_get(v); chk("R10", v, 8'h22);

    // R9: recalibrate on a drive that is not ready
    cur_req = "R9";
    drv_ready = 1'b0;
    wr_put(8'h07); wr_put(8'h01);
    idle(IRQ_DELAY + 2);
    wr_put(8'h08); idle(1);
    rd_get(v); chk("R9", v, 8'h69);
    rd_get(v); chk("R9", v, 8'h22);
    drv_ready = 1'b1;

    // R1: recalibrate ready, then a data command replaces the seek interrupt
    cur_req = "R1";
    wr_put(8'h07); wr_put(8'h00);
    cmd9(8'hC6, 8'h00, 8'h00, 8'h00, 8'h01, 8'h02);
    read_res(EXEC_LEN); read_res(7);
    wr_put(8'h08); idle(1);
    rd_get(v); chk("R10", v, 8'h80);

    // R6: unknown opcode after ST0 has low bits set
    cur_req = "R6";
    wr_put(8'h04); wr_put(8'h03); idle(1); read_res(1);
    wr_put(8'h14); idle(1);
    rd_get(v); chk("R6", v, 8'h83);

    // R14: reset in the middle of a command
    cur_req = "R14";
    wr_put(8'h05); wr_put(8'h01);
    @(negedge clk); rst = 1'b1; idle(2); @(negedge clk); rst = 1'b0;
    idle(1);
    chk("R14", msr, 8'h80); chk("R14", {7'd0, irq}, 8'h00);

    idle(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule